// File: doc/BRIEF.md
# Timed-Write Guarded Control Register

This block is an 8-bit control register mapped into a processor's data space. Its top bit is a guard bit that switches off a boundary-scan test port. Software cannot flip that bit with a single store. It must write the same value for the bit twice, and the second store must fall within a short window of cycles. This prevents a stray write from opening or closing the test port. The remaining low bits are ordinary control bits, and each store updates them at once.

The block drives a test-port enable output. That output is high only when the enable fuse input is high and the committed guard bit is clear. While an on-chip debugger is active, stores cannot change the guard bit. Any half-finished unlock attempt is dropped. Readback always shows the committed contents of the register.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: After the asynchronous reset, every register bit reads as 0 and no unlock attempt is pending.
- R2: While the committed guard bit (bit 7) is 0, `tap_en_o` equals `fuse_en_i`.
- R3: While the committed guard bit is 1, `tap_en_o` is 0 whatever `fuse_en_i` is.
- R4: A single store to the register leaves the guard bit unchanged.
- R5: A store that arms the window, followed by a store of the same bit-7 value 1, 2 or 3 cycles later, commits that value. The first store counts as cycle 1 of the 4-cycle window. The new value reads back in the cycle after the second store.
- R6: If the second store comes 4 or more cycles after the first, it does not commit. Instead it arms a fresh window.
- R7: A second store inside the window with a different bit-7 value disarms without committing. The store after that acts as the first of a new pair.
- R8: While `dbg_active_i` is 1, stores neither arm nor commit the guard bit, and a pending window is cancelled.
- R9: Bits 6:0 take the value written on every store to the register address, in the next cycle. This holds whatever the unlock state and whatever `dbg_active_i` is.
- R10: `rdata_o` returns the committed register when `addr_i` equals the register address (default 0x55) and 0 otherwise. Stores to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Data-space address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| fuse_en_i | input | 1 | Test-port enable fuse |
| dbg_active_i | input | 1 | On-chip debugger active |
| tap_en_o | output | 1 | Test-port enable |

## Verification
A store is seen at the clock edge inside its strobe cycle. Both the committed guard bit and the low bits appear at the next falling edge, one register stage later. `rdata_o` and `tap_en_o` are combinational from that state, so every check sets the address at a falling edge and samples 1 ns later. The window boundary is tested by placing the second store after 0, 1, 2 and 3 idle cycles. The expected outcome at each gap comes from the four-cycle rule, with the cycle of the first store counted as cycle 1.

// File: rtl/guard_ctrl_pkg.sv
package guard_ctrl_pkg;
  typedef enum logic {
    WIN_IDLE  = 1'b0,
    WIN_ARMED = 1'b1
  } win_state_e;
endpackage

// File: rtl/guard_ctrl_decode.sv
module guard_ctrl_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h55
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              sel_o,
  output logic              hit_o
);
  assign sel_o = (addr_i == REG_ADDR);
  assign hit_o = sel_o & we_i;
endmodule

// File: rtl/guard_ctrl_window.sv
module guard_ctrl_window
  import guard_ctrl_pkg::*;
#(
  parameter int WINDOW = 4,
  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             val_i,
  input  logic             dbg_i,
  output logic             commit_o,
  output logic             commit_val_o,
  output logic             armed_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    pend_d       = pend_q;
    commit_o     = 1'b0;
    commit_val_o = pend_q;
    if (dbg_i) begin
      state_d = WIN_IDLE;
      cnt_d   = '0;
    end else if (state_q == WIN_IDLE) begin
      if (hit_i) begin
        state_d = WIN_ARMED;
        cnt_d   = CNT_ONE;
        pend_d  = val_i;
      end
    end else if (hit_i) begin
      // second store: commit only on matching value, disarm either way
      commit_o = (val_i == pend_q);
      state_d  = WIN_IDLE;
      cnt_d    = '0;
    end else if (cnt_q == CNT_LAST) begin
      state_d = WIN_IDLE;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign armed_o = (state_q == WIN_ARMED);
  assign pend_o  = pend_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/guard_ctrl_store.sv
module guard_ctrl_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-2:0] low_i,
  input  logic              commit_i,
  input  logic              commit_val_i,
  output logic              lock_o,
  output logic [DATA_W-2:0] low_o
);
  logic              lock_q;
  logic [DATA_W-2:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      low_q  <= '0;
    end else begin
      if (hit_i)    low_q  <= low_i;
      if (commit_i) lock_q <= commit_val_i;
    end
  end

  assign lock_o = lock_q;
  assign low_o  = low_q;
endmodule

// File: rtl/guarded_ctrl_reg.sv
module guarded_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WINDOW = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h55,
  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fuse_en_i,
  input  logic              dbg_active_i,
  output logic              tap_en_o
);
  logic              sel, hit;
  logic              commit, commit_val;
  logic              armed, pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              lock_q;
  logic [DATA_W-2:0] low_q;

  guard_ctrl_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
    .addr_i (addr_i),
    .we_i   (we_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  guard_ctrl_window #(.WINDOW(WINDOW)) u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .val_i        (wdata_i[DATA_W-1]),
    .dbg_i        (dbg_active_i),
    .commit_o     (commit),
    .commit_val_o (commit_val),
    .armed_o      (armed),
    .pend_o       (pend_q),
    .cnt_o        (cnt_q)
  );

  guard_ctrl_store #(.DATA_W(DATA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .low_i        (wdata_i[DATA_W-2:0]),
    .commit_i     (commit),
    .commit_val_i (commit_val),
    .lock_o       (lock_q),
    .low_o        (low_q)
  );

  assign rdata_o  = sel ? {lock_q, low_q} : '0;
  assign tap_en_o = fuse_en_i & ~lock_q;
endmodule

// File: rtl/guarded_ctrl_reg_chk.sv
module guarded_ctrl_reg_chk #(
  parameter int DATA_W = 8,
  parameter int WINDOW = 4,
  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wdata_i,
  input logic              fuse_en_i,
  input logic              dbg_active_i,
  input logic              tap_en_o,
  input logic              hit,
  input logic              armed,
  input logic              pend_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              lock_q,
  input logic [DATA_W-2:0] low_q
);
  assert_lock_blocks_tap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !tap_en_o);

  assert_fuse_drives_tap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> (tap_en_o == fuse_en_i));

  assert_commit_needs_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != $past(lock_q)) |->
      $past(armed && hit && !dbg_active_i && (wdata_i[DATA_W-1] == pend_q)));

  assert_window_expires_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !hit && !dbg_active_i && (cnt_q == CNT_W'(WINDOW - 1))) |=> !armed);

  assert_dbg_disarms_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_active_i |=> (!armed && $stable(lock_q)));

  assert_low_bits_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (low_q == $past(wdata_i[DATA_W-2:0])));
endmodule

bind guarded_ctrl_reg guarded_ctrl_reg_chk #(.DATA_W(DATA_W), .WINDOW(WINDOW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wdata_i      (wdata_i),
  .fuse_en_i    (fuse_en_i),
  .dbg_active_i (dbg_active_i),
  .tap_en_o     (tap_en_o),
  .hit          (hit),
  .armed        (armed),
  .pend_q       (pend_q),
  .cnt_q        (cnt_q),
  .lock_q       (lock_q),
  .low_q        (low_q)
);

// File: tb/guarded_ctrl_reg_bench.sv
`timescale 1ns/1ps
module guarded_ctrl_reg_bench;
  localparam logic [7:0] REG = 8'h55;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = REG;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       fuse_en_i = 1'b1;
  logic       dbg_active_i = 1'b0;
  logic       tap_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  guarded_ctrl_reg u_guarded_ctrl_reg (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .fuse_en_i, .dbg_active_i, .tap_en_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = REG;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    addr_i = REG; #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    rd("R1", 8'h00);
    fuse_en_i = 1'b1; #1;
    chk("R1", {7'd0, tap_en_o}, 8'h01);
  endtask

  task automatic t_fuse;
    fuse_en_i = 1'b0; #1;
    chk("R2", {7'd0, tap_en_o}, 8'h00);
    fuse_en_i = 1'b1; #1;
    chk("R2", {7'd0, tap_en_o}, 8'h01);
  endtask

  task automatic t_single;
    wr(REG, 8'h80);
    rd("R4", 8'h00);
    idle(5);
    rd("R4", 8'h00);
  endtask

  // set and clear the guard bit with a given idle gap between the pair
  task automatic t_pair(input int gap);
    wr(REG, 8'h80); idle(gap); wr(REG, 8'h80);
    rd("R5", 8'h80);
    fuse_en_i = 1'b1; #1;
    chk("R3", {7'd0, tap_en_o}, 8'h00);
    idle(4);
    wr(REG, 8'h00); idle(gap); wr(REG, 8'h00);
    rd("R5", 8'h00);
    idle(4);
  endtask

  task automatic t_late;
    wr(REG, 8'h80); idle(3); wr(REG, 8'h80);
    rd("R6", 8'h00);
    wr(REG, 8'h80);
    rd("R6", 8'h80);
    idle(4);
    wr(REG, 8'h00); wr(REG, 8'h00);
    rd("R6", 8'h00);
    idle(4);
  endtask

  task automatic t_mismatch;
    wr(REG, 8'h80); wr(REG, 8'h00);
    rd("R7", 8'h00);
    wr(REG, 8'h80);
    rd("R7", 8'h00);
    wr(REG, 8'h80);
    rd("R7", 8'h80);
    idle(4);
  endtask

  task automatic t_dbg;
    // guard bit is 1 on entry
    dbg_active_i = 1'b1;
    wr(REG, 8'h00); wr(REG, 8'h00);
    rd("R8", 8'h80);
    dbg_active_i = 1'b0;
    wr(REG, 8'h00);
    dbg_active_i = 1'b1; idle(1); dbg_active_i = 1'b0;
    wr(REG, 8'h00);
    rd("R8", 8'h80);
    wr(REG, 8'h00);
    rd("R8", 8'h00);
    idle(4);
  endtask

  task automatic t_low;
    wr(REG, 8'h2A);
    rd("R9", 8'h2A);
    wr(REG, 8'hD5);
    rd("R9", 8'h55);
    dbg_active_i = 1'b1;
    wr(REG, 8'h13);
    dbg_active_i = 1'b0;
    rd("R9", 8'h13);
    idle(4);
  endtask

  task automatic t_addr;
    wr(8'h10, 8'h7F); wr(8'h10, 8'hFF);
    rd("R10", 8'h13);
    addr_i = 8'h54; #1;
    chk("R10", rdata_o, 8'h00);
    addr_i = REG;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset();
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_fuse();
    t_single();
    for (int g = 0; g < 3; g++) t_pair(g);
    t_late();
    t_mismatch();
    t_dbg();
    t_low();
    t_addr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule